// File: doc/BRIEF.md
# Coprocessor Result Handshake Gate

This block sits between a processor core and a fixed-latency pipelined math unit. The core issues a command with two operands. A command issued on a clock edge lands LAT edges later as an X/Y pair. Each core has one result register pair, so only one landed result is kept until the core reads it. The block tracks how many commands are still inside the pipeline and whether each result half holds unread data. From these it decides whether a read strobe must wait, can take the held value, or must complete at once and flag that nothing was there.

A small stand-in pipeline replaces the real arithmetic. It delays the operands by LAT stages and returns their sum as X and their difference as Y. Each stage carries a valid bit that reset clears, so a result that was in flight before reset is never delivered.

Read strobes take effect in the cycle they are raised. When the stall output is low, the result outputs already show the value being read. If the core reads both halves, one after the other, while no command is outstanding, both reads complete without waiting. This lets the core flush stale results at start-up without any risk of hanging.

Top module: `mrc_result_gate`

## Requirements
- R1: While reset is low and after it is released, the outstanding count, both done flags and both result halves are zero, stall and rd_err are low, and no command issued before reset ever lands.
- R2: A command issued on edge N lands on edge N+LAT (LAT = 3 by default), provided the target half is free. Landing writes result_x = a+b and result_y = a-b, each modulo 2^DW, and raises done_x/done_y.
- R3: in_progress is high exactly while at least one issued command has not yet left the pipeline. An issue and a landing on the same edge leave it unchanged.
- R4: An issue clears both done flags on that edge, unless a result lands on the same edge, in which case the landed result is stored and its flag is set.
- R5: A read of one half that is not stalled clears that half's done flag on the next edge and leaves the other half's flag unchanged.
- R6: While a half's done flag is set and no issue or completed read of that half clears it, later landings are dropped and the held value stays unchanged.
- R7: stall is high only when a strobed half has its done flag clear while in_progress is high. While stall is high, neither strobed half is consumed.
- R8: A strobed half with its done flag clear and nothing in flight completes in the same cycle with stall low, keeps its held value (zero after reset), and raises rd_err for that cycle only.
- R9: Once the pipeline is empty, a read of X followed by a read of Y on consecutive cycles completes without a single stall cycle.
- R10: One command can be issued every cycle. With LAT = 3 this gives at most three in flight, and results land in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Issue a command this cycle |
| cmd_a | input | DW | First operand |
| cmd_b | input | DW | Second operand |
| rd_x | input | 1 | Read strobe for the X half |
| rd_y | input | 1 | Read strobe for the Y half |
| stall | output | 1 | Read must wait (a strobed half is still pending) |
| rd_err | output | 1 | Read completed with nothing pending or held |
| result_x | output | DW | Held X result |
| result_y | output | DW | Held Y result |
| in_progress | output | 1 | At least one command is in flight |
| done_x | output | 1 | X half holds an unread result |
| done_y | output | 1 | Y half holds an unread result |

## Verification
A command issued on edge N is first visible on result, done and in_progress after edge N+LAT. in_progress rises after edge N. stall and rd_err depend combinationally on the strobes, so they are due in the same cycle as the strobe. The bench drives inputs on the falling edge. It checks the registered outputs just before driving, and checks stall and rd_err one nanosecond after driving. A behavioural model of landing times, kept as a queue, then advances on the rising edge. Directed cases run the stalled-read count, the three-deep overrun, and the empty flush. A randomised run follows, in which every output is compared every cycle.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    // Classification of one result half as seen by a read strobe
    typedef enum logic [1:0] {
        HALF_EMPTY = 2'd0,   // nothing held, nothing in flight
        HALF_WAIT  = 2'd1,   // nothing held, commands in flight
        HALF_READY = 2'd2    // unread result held
    } half_e;

    localparam int unsigned HALF_X = 0;
    localparam int unsigned HALF_Y = 1;
    localparam int unsigned N_HALF = 2;

endpackage

// File: rtl/mrc_pipe.sv
module mrc_pipe #(
    parameter int unsigned DW  = 16,
    parameter int unsigned LAT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_v,
    input  logic [DW-1:0]        in_a,
    input  logic [DW-1:0]        in_b,
    output logic                 out_v,
    output logic [DW-1:0]        out_x,
    output logic [DW-1:0]        out_y,
    output logic                 busy
);

    typedef struct packed {
        logic [LAT-1:0]          vld;
        logic [LAT-1:0][DW-1:0]  a;
        logic [LAT-1:0][DW-1:0]  b;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.vld[0] = in_v;
        pipe_d.a[0]   = in_a;
        pipe_d.b[0]   = in_b;
        for (int i = 1; i < LAT; i++) begin
            pipe_d.vld[i] = pipe_q.vld[i-1];
            pipe_d.a[i]   = pipe_q.a[i-1];
            pipe_d.b[i]   = pipe_q.b[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_v = pipe_q.vld[LAT-1];
    assign out_x = pipe_q.a[LAT-1] + pipe_q.b[LAT-1];
    assign out_y = pipe_q.a[LAT-1] - pipe_q.b[LAT-1];
    assign busy  = |pipe_q.vld;

    initial begin
        assert_lat_min_R10: assert (LAT >= 2)
            else $error("pipeline latency must be at least 2");
    end

endmodule

// File: rtl/mrc_track.sv
module mrc_track
    import mrc_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned MAXC  = 3,
    parameter int unsigned CNT_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue,
    input  logic                       land,
    input  logic [N_HALF-1:0][DW-1:0]  land_data,
    input  logic [N_HALF-1:0]          rd_req,
    output logic                       stall,
    output logic                       rd_err,
    output logic                       busy,
    output logic [N_HALF-1:0]          done,
    output logic [N_HALF-1:0][DW-1:0]  hold
);

    typedef struct packed {
        logic [CNT_W-1:0]           cnt;
        logic [N_HALF-1:0]          done;
        logic [N_HALF-1:0][DW-1:0]  hold;
    } trk_t;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAXC);

    trk_t  trk_d, trk_q;
    half_e hs [N_HALF];
    logic  keep [N_HALF];

    always_comb begin
        busy   = (trk_q.cnt != '0);
        stall  = 1'b0;
        rd_err = 1'b0;
        for (int h = 0; h < N_HALF; h++) begin
            if (trk_q.done[h]) hs[h] = HALF_READY;
            else if (busy)     hs[h] = HALF_WAIT;
            else               hs[h] = HALF_EMPTY;
            if (rd_req[h] && hs[h] == HALF_WAIT)  stall  = 1'b1;
            if (rd_req[h] && hs[h] == HALF_EMPTY) rd_err = 1'b1;
        end

        trk_d = trk_q;
        case ({issue, land})
            2'b10:   trk_d.cnt = trk_q.cnt + CNT_ONE;
            2'b01:   trk_d.cnt = trk_q.cnt - CNT_ONE;
            default: trk_d.cnt = trk_q.cnt;
        endcase

        for (int h = 0; h < N_HALF; h++) begin
            keep[h] = trk_q.done[h] && !issue && !(rd_req[h] && !stall);
            if (land && !keep[h]) begin
                trk_d.hold[h] = land_data[h];
                trk_d.done[h] = 1'b1;
            end else begin
                trk_d.done[h] = keep[h];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign done = trk_q.done;
    assign hold = trk_q.hold;

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(trk_q.cnt == CNT_MAX && issue && !land));

    assert_err_not_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> !stall);

    for (genvar g = 0; g < N_HALF; g++) begin : g_half_chk
        assert_done_from_land_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trk_q.done[g]) |-> $past(land));

        assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (trk_q.done[g] && !issue && !(rd_req[g] && !stall)) |=> $stable(trk_q.hold[g]));

        assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req[g] && !stall && !land) |=> !trk_q.done[g]);
    end

endmodule

// File: rtl/mrc_result_gate.sv
module mrc_result_gate
    import mrc_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned LAT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [DW-1:0]  cmd_a,
    input  logic [DW-1:0]  cmd_b,
    input  logic           rd_x,
    input  logic           rd_y,
    output logic           stall,
    output logic           rd_err,
    output logic [DW-1:0]  result_x,
    output logic [DW-1:0]  result_y,
    output logic           in_progress,
    output logic           done_x,
    output logic           done_y
);

    localparam int unsigned CNT_W = $clog2(LAT + 1);

    logic                      land_v;
    logic [DW-1:0]             land_x, land_y;
    logic                      pipe_busy;
    logic [N_HALF-1:0][DW-1:0] land_data;
    logic [N_HALF-1:0][DW-1:0] hold;
    logic [N_HALF-1:0]         done;
    logic [N_HALF-1:0]         rd_req;

    mrc_pipe #(.DW(DW), .LAT(LAT)) i_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (cmd_valid),
        .in_a  (cmd_a),
        .in_b  (cmd_b),
        .out_v (land_v),
        .out_x (land_x),
        .out_y (land_y),
        .busy  (pipe_busy)
    );

    assign land_data[HALF_X] = land_x;
    assign land_data[HALF_Y] = land_y;
    assign rd_req[HALF_X]    = rd_x;
    assign rd_req[HALF_Y]    = rd_y;

    mrc_track #(.DW(DW), .MAXC(LAT), .CNT_W(CNT_W)) i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (cmd_valid),
        .land      (land_v),
        .land_data (land_data),
        .rd_req    (rd_req),
        .stall     (stall),
        .rd_err    (rd_err),
        .busy      (in_progress),
        .done      (done),
        .hold      (hold)
    );

    assign result_x = hold[HALF_X];
    assign result_y = hold[HALF_Y];
    assign done_x   = done[HALF_X];
    assign done_y   = done[HALF_Y];

    assert_count_tracks_pipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_progress == pipe_busy);

    assert_stall_needs_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> pipe_busy);

endmodule

// File: tb/test_mrc_result_gate.sv
module test_mrc_result_gate;

    localparam int unsigned DW  = 16;
    localparam int unsigned LAT = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [DW-1:0] cmd_a = '0, cmd_b = '0;
    logic          rd_x = 1'b0, rd_y = 1'b0;
    logic          stall, rd_err, in_progress, done_x, done_y;
    logic [DW-1:0] result_x, result_y;

    mrc_result_gate #(.DW(DW), .LAT(LAT)) i_mrc_result_gate (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .rd_x(rd_x), .rd_y(rd_y), .stall(stall), .rd_err(rd_err),
        .result_x(result_x), .result_y(result_y), .in_progress(in_progress),
        .done_x(done_x), .done_y(done_y)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;

    // reference model: landing times and values of commands in flight
    int            q_due[$];
    logic [DW-1:0] q_x[$];
    logic [DW-1:0] q_y[$];
    logic          m_dx = 0, m_dy = 0;
    logic [DW-1:0] m_bx = '0, m_by = '0;
    logic          seen_stall, seen_err;

    function automatic void chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endfunction

    task automatic model_clear();
        q_due.delete(); q_x.delete(); q_y.delete();
        m_dx = 0; m_dy = 0; m_bx = '0; m_by = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 0; rd_x = 0; rd_y = 0; cmd_a = '0; cmd_b = '0;
        repeat (3) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
    endtask

    task automatic step(input logic cv, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic rx, input logic ry);
        logic busy_m, lack, e_stall, e_err, land, kx, ky;
        @(negedge clk);
        chk("R2", "result_x", result_x, m_bx);
        chk("R2", "result_y", result_y, m_by);
        chk("R3", "in_progress", in_progress, q_due.size() != 0);
        chk("R4", "done_x", done_x, m_dx);
        chk("R4", "done_y", done_y, m_dy);
        cmd_valid = cv; cmd_a = a; cmd_b = b; rd_x = rx; rd_y = ry;
        #1;
        busy_m  = (q_due.size() != 0);
        lack    = (rx && !m_dx) || (ry && !m_dy);
        e_stall = lack && busy_m;
        e_err   = lack && !busy_m;
        seen_stall = stall;
        seen_err   = rd_err;
        chk("R7", "stall", stall, e_stall);
        chk("R8", "rd_err", rd_err, e_err);
        @(posedge clk);
        cyc++;
        land = (q_due.size() != 0) && (q_due[0] == cyc);
        kx = m_dx && !cv && !(rx && !e_stall);
        ky = m_dy && !cv && !(ry && !e_stall);
        if (land && !kx) begin m_bx = q_x[0]; m_dx = 1; end else m_dx = kx;
        if (land && !ky) begin m_by = q_y[0]; m_dy = 1; end else m_dy = ky;
        if (land) begin void'(q_due.pop_front()); void'(q_x.pop_front()); void'(q_y.pop_front()); end
        if (cv) begin q_due.push_back(cyc + LAT); q_x.push_back(a + b); q_y.push_back(a - b); end
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int stalls;
        do_reset();
        // R1: reset state
        #1;
        chk("R1", "result_x reset", result_x, 0);
        chk("R1", "result_y reset", result_y, 0);
        chk("R1", "done reset", {done_x, done_y}, 0);
        chk("R1", "in_progress reset", in_progress, 0);
        chk("R1", "stall reset", stall, 0);

        // R2: single command lands after LAT edges
        step(1, 16'd5, 16'd3, 0, 0);
        idle(LAT - 1);
        chk("R2", "done before land", done_x, 0);
        idle(1);
        chk("R2", "x after land", result_x, 8);
        chk("R2", "y after land", result_y, 2);
        // R5: read X only
        step(0, '0, '0, 1, 0);
        chk("R5", "done_x after read", done_x, 0);
        chk("R5", "done_y untouched", done_y, 1);
        step(0, '0, '0, 0, 1);

        // R7: early read stalls until landing
        step(1, 16'd100, 16'd1, 0, 0);
        stalls = 0;
        step(0, '0, '0, 1, 1);
        while (seen_stall && stalls < 20) begin stalls++; step(0, '0, '0, 1, 1); end
        chk("R7", "stalled cycles", stalls, LAT);
        chk("R7", "value after stall", result_x, 101);

        // R6: three in flight, reads late: only the first kept
        step(1, 16'd10, 16'd1, 0, 0);
        step(1, 16'd20, 16'd2, 0, 0);
        step(1, 16'd30, 16'd3, 0, 0);
        idle(LAT + 3);
        chk("R6", "first x kept", result_x, 11);
        chk("R6", "first y kept", result_y, 9);
        chk("R3", "pipe drained", in_progress, 0);

        // R9 / R8: flush with nothing left
        step(0, '0, '0, 1, 0);
        chk("R9", "flush x no stall", seen_stall, 0);
        step(0, '0, '0, 0, 1);
        chk("R9", "flush y no stall", seen_stall, 0);
        step(0, '0, '0, 1, 0);
        chk("R8", "empty read err", seen_err, 1);
        chk("R8", "empty read keeps value", result_x, 11);
        idle(1);
        chk("R8", "err one cycle", rd_err, 0);

        // R4: issue clears held flags
        step(1, 16'd7, 16'd7, 0, 0);
        step(1, 16'd1, 16'd2, 0, 0);
        idle(LAT);
        chk("R4", "done after land", done_x, 1);
        step(1, 16'd3, 16'd4, 0, 0);
        chk("R4", "issue clears done", done_x, 0);
        idle(LAT + 1);

        // R10: back-to-back issue, read each on arrival: in order
        step(1, 16'd1, 16'd0, 0, 0);
        step(1, 16'd2, 16'd0, 0, 0);
        step(1, 16'd3, 16'd0, 0, 0);
        chk("R10", "three in flight", in_progress, 1);
        step(0, '0, '0, 1, 1);
        chk("R10", "first in order", result_x, 1);
        step(0, '0, '0, 1, 1);
        chk("R10", "second in order", result_x, 2);
        step(0, '0, '0, 1, 1);
        chk("R10", "third in order", result_x, 3);

        // R1: reset mid-flight discards in-flight results
        step(1, 16'd50, 16'd50, 0, 0);
        do_reset();
        idle(LAT + 2);
        chk("R1", "no stale landing", done_x, 0);
        chk("R1", "no stale value", result_x, 0);

        // randomised traffic compared every cycle
        for (int i = 0; i < 2000; i++)
            step(($urandom % 3) == 0, DW'($urandom), DW'($urandom),
                 ($urandom % 4) == 0, ($urandom % 4) == 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule